// File: doc/BRIEF.md
# Low-Power Stop Mode Sequencer

This block steers a small processor core between normal execution and two
stop levels. A stop strobe from the core picks light stop or deep stop. In
light stop only the core clock halts. In deep stop most of the logic is
treated as unpowered, and the pin control values are frozen in a hold latch.
Leaving deep stop always runs a fixed-length internal reset, as if from power
on. The pin hold and a recovery flag then stay set until software
acknowledges them through the single control/status register.

A debug port takes two-bit commands. When debug is enabled, stop never goes
deeper than light stop. The debug logic keeps its clock, the regulator stays
in full regulation, and a background command can pull the core out of stop
into a halted debug state. The states are RUN, LIGHT (light stop), DEEP (deep
stop), WRST (internal reset hold) and DEBUG. The transitions are:

- stop: RUN to LIGHT or DEEP
- wake: LIGHT to RUN
- deep-wake: DEEP to WRST
- reset: RUN, LIGHT or DEBUG to WRST
- release: WRST to RUN
- background: RUN or LIGHT to DEBUG
- go: DEBUG to RUN

Top module: `stopseq_top`

## Requirements
- R1: After power-on reset (`por_n` low) the block is in RUN with `core_clk_en`=1, `dbg_clk_en`=1, `reg_full_en`=1, `core_pwr_en`=1, `reset_req`=0, `in_debug`=0, `pin_hold`=0, `reg_rdata`=0 and `dbg_status`=0.
- R2: A stop strobe in RUN enters DEEP when config bit 1 (deep select) is 1 and bit 0 (debug enable) is 0. Otherwise it enters LIGHT. Both stop states clear `core_clk_en`, and DEEP also clears `core_pwr_en`.
- R3: In a stop state, `dbg_clk_en` and `reg_full_en` stay 1 only if debug enable is set. Debug enable never lets DEEP be entered.
- R4: LIGHT returns to RUN on the next edge when `wake_pin_n` is low, or when `timer_wake` is high and config bit 2 (timer wake enable) is 1. `ext_reset` in RUN, LIGHT or DEBUG enters WRST.
- R5: DEEP goes to WRST when `ext_reset` is high, `wake_pin_n` is low, or an enabled timer wake occurs. A timer wake with bit 2 clear is ignored. A wake pin already low at the stop strobe still enters DEEP, which then exits on the next edge.
- R6: `reset_req` is high for exactly 8 cycles in WRST, then RUN is re-entered. During WRST config bits 2..0 return to 0.
- R7: Leaving DEEP sets the recovery flag, read at `reg_rdata` bit 3. A reset sequence that starts outside DEEP leaves it unchanged.
- R8: On entry to DEEP, `pin_ctrl_in` is captured if no hold is active, and `pin_hold` rises. While held, `pin_ctrl_out` shows the captured value. Otherwise it follows `pin_ctrl_in`.
- R9: Writing 1 to bit 4 (acknowledge) clears both the recovery flag and the pin hold. Writing 0 there has no effect, and bit 4 always reads 0.
- R10: A stop strobe in RUN in the same cycle as an enabled timer wake is dropped, and the block stays in RUN.
- R11: Debug status appears one cycle after a command, with codes 0 none, 1 ok, 2 stopped, 3 rejected. In LIGHT with debug enabled, a memory command (code 1) or go (code 3) returns 2. In a stop state without debug clocks, nothing is returned.
- R12: Background (code 2) enters DEBUG from RUN or LIGHT only if debug enable is set, answering 1. Without debug enable, in RUN it answers 3. In DEBUG every command answers 1, and go returns to RUN.
- R13: Register writes take effect only in RUN or DEBUG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| stop_strobe | input | 1 | Stop instruction executed |
| ext_reset | input | 1 | External reset request, synchronous |
| wake_pin_n | input | 1 | External wake pin, active low |
| timer_wake | input | 1 | Wake event from periodic timer |
| dbg_valid | input | 1 | Debug command valid |
| dbg_cmd | input | 2 | Debug command: 0 nop, 1 memory, 2 background, 3 go |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | DW | Write data |
| pin_ctrl_in | input | N_PINS | Live pin control values |
| reg_rdata | output | DW | Register read value |
| pin_ctrl_out | output | N_PINS | Pin control values after hold latch |
| pin_hold | output | 1 | Pin hold active |
| core_clk_en | output | 1 | Core clock enable |
| dbg_clk_en | output | 1 | Debug logic clock enable |
| reg_full_en | output | 1 | Regulator full regulation (0 = standby) |
| core_pwr_en | output | 1 | Core power domain on |
| reset_req | output | 1 | Internal reset request |
| in_debug | output | 1 | Halted in debug state |
| dbg_status | output | 2 | Debug command status |

## Verification
The bench drives inputs just after a rising edge and samples 2 ns after the
following edge. At that point, state-derived enables, `reset_req`, `pin_hold`
and register contents show the effect of the stimulus one edge earlier. The
debug status is registered, so it also appears at that one-edge sample. The
only multi-cycle result is the release from WRST, which the bench counts as
exactly eight samples with `reset_req` high. A reference model updated on the
same edge compares every output each cycle, so no result is sampled early or
late.

// File: rtl/stopseq_pkg.sv
package stopseq_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_LIGHT,
        ST_DEEP,
        ST_WRST,
        ST_DEBUG
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_MEM,
        CMD_BKGD,
        CMD_GO
    } dbg_cmd_e;

    typedef enum logic [1:0] {
        RSP_NONE,
        RSP_OK,
        RSP_STOPPED,
        RSP_REJECT
    } dbg_rsp_e;

    // bit 0 debug enable, bit 1 deep select, bit 2 timer wake enable
    typedef struct packed {
        logic tmr_en;
        logic deep_sel;
        logic dbg_en;
    } seq_cfg_t;

    localparam int CFG_LO   = 0;
    localparam int CFG_HI   = 2;
    localparam int CSR_FLAG = 3;
    localparam int CSR_ACK  = 4;

endpackage

// File: rtl/stopseq_fsm.sv
module stopseq_fsm
    import stopseq_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       stop_strobe,
    input  logic       ext_reset,
    input  logic       wake_pin_n,
    input  logic       timer_wake,
    input  seq_cfg_t   cfg,
    input  logic       bkgd_take,
    input  logic       go_take,
    output seq_state_e state,
    output logic       enter_deep,
    output logic       deep_wake,
    output logic       sys_rst,
    output logic       core_clk_en,
    output logic       dbg_clk_en,
    output logic       reg_full_en,
    output logic       core_pwr_en,
    output logic       in_debug
);

    localparam int          CW   = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    seq_state_e    state_nx;
    logic [CW-1:0] cnt_q;
    logic          tmr_ev;
    logic          wake_ev;

    assign tmr_ev  = timer_wake && cfg.tmr_en;
    assign wake_ev = !wake_pin_n || tmr_ev;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (ext_reset)                  state_nx = ST_WRST;
                else if (bkgd_take)             state_nx = ST_DEBUG;
                else if (stop_strobe && !tmr_ev)
                    state_nx = (cfg.deep_sel && !cfg.dbg_en) ? ST_DEEP : ST_LIGHT;
            end
            ST_LIGHT: begin
                if (ext_reset)                  state_nx = ST_WRST;
                else if (wake_ev)               state_nx = ST_RUN;
                else if (bkgd_take)             state_nx = ST_DEBUG;
            end
            ST_DEEP: begin
                if (ext_reset || wake_ev)       state_nx = ST_WRST;
            end
            ST_WRST: begin
                if (cnt_q == LAST)              state_nx = ST_RUN;
            end
            ST_DEBUG: begin
                if (ext_reset)                  state_nx = ST_WRST;
                else if (go_take)               state_nx = ST_RUN;
            end
            default:                            state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                                       cnt_q <= '0;
        else if (state == ST_WRST && state_nx == ST_WRST) cnt_q <= cnt_q + 1'b1;
        else                                              cnt_q <= '0;
    end

    always_comb begin
        core_clk_en = 1'b0;
        dbg_clk_en  = 1'b1;
        reg_full_en = 1'b1;
        core_pwr_en = 1'b1;
        sys_rst     = 1'b0;
        in_debug    = 1'b0;
        unique case (state)
            ST_RUN:   core_clk_en = 1'b1;
            ST_LIGHT: begin
                dbg_clk_en  = cfg.dbg_en;
                reg_full_en = cfg.dbg_en;
            end
            ST_DEEP: begin
                dbg_clk_en  = 1'b0;
                reg_full_en = 1'b0;
                core_pwr_en = 1'b0;
            end
            ST_WRST:  sys_rst = 1'b1;
            ST_DEBUG: begin
                core_clk_en = 1'b1;
                in_debug    = 1'b1;
            end
            default:  core_clk_en = 1'b0;
        endcase
        enter_deep = (state != ST_DEEP) && (state_nx == ST_DEEP);
        deep_wake  = (state == ST_DEEP) && (state_nx == ST_WRST);
    end

endmodule

// File: rtl/stopseq_dbg.sv
module stopseq_dbg
    import stopseq_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  seq_state_e state,
    input  logic       dbg_en,
    input  logic       dbg_valid,
    input  logic [1:0] dbg_cmd,
    output logic       bkgd_take,
    output logic       go_take,
    output logic [1:0] dbg_status
);

    dbg_cmd_e cmd;
    dbg_rsp_e rsp_nx;

    assign cmd = dbg_cmd_e'(dbg_cmd);

    assign bkgd_take = dbg_valid && (cmd == CMD_BKGD) && dbg_en &&
                       (state == ST_RUN || state == ST_LIGHT);
    assign go_take   = dbg_valid && (cmd == CMD_GO) && (state == ST_DEBUG);

    always_comb begin
        rsp_nx = RSP_NONE;
        if (dbg_valid && cmd != CMD_NOP) begin
            unique case (state)
                ST_RUN: begin
                    if (cmd == CMD_MEM)       rsp_nx = RSP_OK;
                    else if (cmd == CMD_BKGD) rsp_nx = dbg_en ? RSP_OK : RSP_REJECT;
                    else                      rsp_nx = RSP_REJECT;
                end
                ST_LIGHT: begin
                    if (!dbg_en)              rsp_nx = RSP_NONE;
                    else if (cmd == CMD_BKGD) rsp_nx = RSP_OK;
                    else                      rsp_nx = RSP_STOPPED;
                end
                ST_DEBUG:                     rsp_nx = RSP_OK;
                ST_DEEP, ST_WRST:             rsp_nx = RSP_NONE;
                default:                      rsp_nx = RSP_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) dbg_status <= RSP_NONE;
        else        dbg_status <= rsp_nx;
    end

endmodule

// File: rtl/stopseq_csr.sv
module stopseq_csr
    import stopseq_pkg::*;
#(
    parameter int DW     = 8,
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              wr_ok,
    input  logic              sys_rst,
    input  logic              enter_deep,
    input  logic              deep_wake,
    input  logic [N_PINS-1:0] pin_ctrl_in,
    output seq_cfg_t          cfg,
    output logic [DW-1:0]     reg_rdata,
    output logic              pin_hold,
    output logic [N_PINS-1:0] pin_ctrl_out
);

    logic              wr_en;
    logic              ack;
    logic              flag_q;
    logic [N_PINS-1:0] latch_q;
    logic              unused_wdata;

    assign wr_en        = reg_wr && wr_ok;
    assign ack          = wr_en && reg_wdata[CSR_ACK];
    assign unused_wdata = ^reg_wdata[DW-1:CSR_ACK+1];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cfg      <= '0;
            flag_q   <= 1'b0;
            pin_hold <= 1'b0;
            latch_q  <= '0;
        end else begin
            if (sys_rst)    cfg <= '0;
            else if (wr_en) cfg <= seq_cfg_t'(reg_wdata[CFG_HI:CFG_LO]);

            if (deep_wake) flag_q <= 1'b1;
            else if (ack)  flag_q <= 1'b0;

            if (enter_deep) pin_hold <= 1'b1;
            else if (ack)   pin_hold <= 1'b0;

            if (enter_deep && !pin_hold) latch_q <= pin_ctrl_in;
        end
    end

    always_comb begin
        reg_rdata                = '0;
        reg_rdata[CFG_HI:CFG_LO] = cfg;
        reg_rdata[CSR_FLAG]      = flag_q;
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        assign pin_ctrl_out[i] = pin_hold ? latch_q[i] : pin_ctrl_in[i];
    end

endmodule

// File: rtl/stopseq_top.sv
module stopseq_top
    import stopseq_pkg::*;
#(
    parameter int DW         = 8,
    parameter int N_PINS     = 8,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              stop_strobe,
    input  logic              ext_reset,
    input  logic              wake_pin_n,
    input  logic              timer_wake,
    input  logic              dbg_valid,
    input  logic [1:0]        dbg_cmd,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [N_PINS-1:0] pin_ctrl_in,
    output logic [DW-1:0]     reg_rdata,
    output logic [N_PINS-1:0] pin_ctrl_out,
    output logic              pin_hold,
    output logic              core_clk_en,
    output logic              dbg_clk_en,
    output logic              reg_full_en,
    output logic              core_pwr_en,
    output logic              reset_req,
    output logic              in_debug,
    output logic [1:0]        dbg_status
);

    seq_state_e state;
    seq_cfg_t   cfg;
    logic       bkgd_take;
    logic       go_take;
    logic       enter_deep;
    logic       deep_wake;
    logic       wr_ok;

    assign wr_ok = (state == ST_RUN) || (state == ST_DEBUG);

    stopseq_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .stop_strobe (stop_strobe),
        .ext_reset   (ext_reset),
        .wake_pin_n  (wake_pin_n),
        .timer_wake  (timer_wake),
        .cfg         (cfg),
        .bkgd_take   (bkgd_take),
        .go_take     (go_take),
        .state       (state),
        .enter_deep  (enter_deep),
        .deep_wake   (deep_wake),
        .sys_rst     (reset_req),
        .core_clk_en (core_clk_en),
        .dbg_clk_en  (dbg_clk_en),
        .reg_full_en (reg_full_en),
        .core_pwr_en (core_pwr_en),
        .in_debug    (in_debug)
    );

    stopseq_dbg u_dbg (
        .clk        (clk),
        .por_n      (por_n),
        .state      (state),
        .dbg_en     (cfg.dbg_en),
        .dbg_valid  (dbg_valid),
        .dbg_cmd    (dbg_cmd),
        .bkgd_take  (bkgd_take),
        .go_take    (go_take),
        .dbg_status (dbg_status)
    );

    stopseq_csr #(.DW(DW), .N_PINS(N_PINS)) u_csr (
        .clk          (clk),
        .por_n        (por_n),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .wr_ok        (wr_ok),
        .sys_rst      (reset_req),
        .enter_deep   (enter_deep),
        .deep_wake    (deep_wake),
        .pin_ctrl_in  (pin_ctrl_in),
        .cfg          (cfg),
        .reg_rdata    (reg_rdata),
        .pin_hold     (pin_hold),
        .pin_ctrl_out (pin_ctrl_out)
    );

endmodule

// File: rtl/stopseq_chk.sv
module stopseq_chk #(
    parameter int DW         = 8,
    parameter int RST_CYCLES = 8
) (
    input logic          clk,
    input logic          por_n,
    input logic          stop_strobe,
    input logic          ext_reset,
    input logic          timer_wake,
    input logic          reg_wr,
    input logic [DW-1:0] reg_rdata,
    input logic          pin_hold,
    input logic          core_clk_en,
    input logic          dbg_clk_en,
    input logic          core_pwr_en,
    input logic          reset_req,
    input logic          in_debug,
    input logic [1:0]    dbg_status
);

    logic [7:0] run_len;
    logic       unused_rd;

    assign unused_rd = ^reg_rdata;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                             run_len <= '0;
        else if (!reset_req)                    run_len <= '0;
        else if (run_len != 8'hff)              run_len <= run_len + 1'b1;
    end

    // R3
    deep_no_dbg_clk_chk: assert property (@(posedge clk) disable iff (!por_n)
        !core_pwr_en |-> !dbg_clk_en);

    // R8
    deep_pins_held_chk: assert property (@(posedge clk) disable iff (!por_n)
        !core_pwr_en |-> pin_hold);

    // R5
    deep_exit_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        !core_pwr_en |=> (!core_pwr_en || reset_req));

    // R6
    reset_len_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(reset_req) |-> (run_len == 8'(RST_CYCLES)));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (reg_rdata[3] && !reg_wr) |=> reg_rdata[3]);

    // R10
    wake_beats_stop_chk: assert property (@(posedge clk) disable iff (!por_n)
        (core_clk_en && !in_debug && !ext_reset && stop_strobe && timer_wake && reg_rdata[2])
        |=> core_clk_en);

    // R11
    silent_dbg_chk: assert property (@(posedge clk) disable iff (!por_n)
        !dbg_clk_en |=> (dbg_status == 2'd0));

endmodule

bind stopseq_top stopseq_chk #(.DW(DW), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .stop_strobe (stop_strobe),
    .ext_reset   (ext_reset),
    .timer_wake  (timer_wake),
    .reg_wr      (reg_wr),
    .reg_rdata   (reg_rdata),
    .pin_hold    (pin_hold),
    .core_clk_en (core_clk_en),
    .dbg_clk_en  (dbg_clk_en),
    .core_pwr_en (core_pwr_en),
    .reset_req   (reset_req),
    .in_debug    (in_debug),
    .dbg_status  (dbg_status)
);

// File: tb/tb_stopseq_top.sv
`timescale 1ns/1ps
module tb_stopseq_top;

    localparam int DW = 8;
    localparam int NP = 8;
    localparam int M_RUN = 0, M_LIGHT = 1, M_DEEP = 2, M_WRST = 3, M_DBG = 4;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic stop_strobe = 0, ext_reset = 0, wake_pin_n = 1, timer_wake = 0;
    logic dbg_valid = 0;
    logic [1:0] dbg_cmd = 0;
    logic reg_wr = 0;
    logic [DW-1:0] reg_wdata = 0;
    logic [NP-1:0] pin_ctrl_in = 0;
    logic [DW-1:0] reg_rdata;
    logic [NP-1:0] pin_ctrl_out;
    logic pin_hold, core_clk_en, dbg_clk_en, reg_full_en, core_pwr_en;
    logic reset_req, in_debug;
    logic [1:0] dbg_status;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_st = M_RUN;
    int m_cnt = 0;
    logic [2:0] m_cfg = 0;
    logic m_flag = 0, m_hold = 0;
    logic [NP-1:0] m_latch = 0;
    logic [1:0] m_stat = 0;

    always #10 clk = ~clk;

    stopseq_top dut (
        .clk(clk), .por_n(por_n), .stop_strobe(stop_strobe), .ext_reset(ext_reset),
        .wake_pin_n(wake_pin_n), .timer_wake(timer_wake), .dbg_valid(dbg_valid),
        .dbg_cmd(dbg_cmd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .pin_ctrl_in(pin_ctrl_in), .reg_rdata(reg_rdata), .pin_ctrl_out(pin_ctrl_out),
        .pin_hold(pin_hold), .core_clk_en(core_clk_en), .dbg_clk_en(dbg_clk_en),
        .reg_full_en(reg_full_en), .core_pwr_en(core_pwr_en), .reset_req(reset_req),
        .in_debug(in_debug), .dbg_status(dbg_status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_status(input int st, input logic [2:0] cfg,
                                              input logic v, input logic [1:0] c);
        if (!v || c == 2'd0) return 2'd0;
        case (st)
            M_RUN:   return (c == 2'd1) ? 2'd1 : (c == 2'd2 && cfg[0]) ? 2'd1 : 2'd3;
            M_LIGHT: return !cfg[0] ? 2'd0 : (c == 2'd2) ? 2'd1 : 2'd2;
            M_DBG:   return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    task automatic compare_all();
        logic stopd;
        stopd = (m_st == M_LIGHT) || (m_st == M_DEEP);
        chk("R2 core_clk_en", core_clk_en, (m_st == M_RUN) || (m_st == M_DBG));
        chk("R2 core_pwr_en", core_pwr_en, m_st != M_DEEP);
        chk("R3 dbg_clk_en", dbg_clk_en, !stopd || (m_st == M_LIGHT && m_cfg[0]));
        chk("R3 reg_full_en", reg_full_en, !stopd || (m_st == M_LIGHT && m_cfg[0]));
        chk("R6 reset_req", reset_req, m_st == M_WRST);
        chk("R12 in_debug", in_debug, m_st == M_DBG);
        chk("R7 R9 reg_rdata", reg_rdata, {4'b0, m_flag, m_cfg});
        chk("R8 pin_hold", pin_hold, m_hold);
        chk("R8 pin_ctrl_out", pin_ctrl_out, m_hold ? m_latch : pin_ctrl_in);
        chk("R11 dbg_status", dbg_status, m_stat);
    endtask

    task automatic tick();
        logic tev, wev, bk, go, wok;
        int n_st, n_cnt;
        logic [2:0] n_cfg;
        logic n_flag, n_hold;
        logic [NP-1:0] n_latch;
        tev = timer_wake && m_cfg[2];
        wev = !wake_pin_n || tev;
        bk  = dbg_valid && dbg_cmd == 2'd2 && m_cfg[0] && (m_st == M_RUN || m_st == M_LIGHT);
        go  = dbg_valid && dbg_cmd == 2'd3 && m_st == M_DBG;
        n_st = m_st;
        case (m_st)
            M_RUN:   if (ext_reset) n_st = M_WRST; else if (bk) n_st = M_DBG;
                     else if (stop_strobe && !tev)
                         n_st = (m_cfg[1] && !m_cfg[0]) ? M_DEEP : M_LIGHT;
            M_LIGHT: if (ext_reset) n_st = M_WRST; else if (wev) n_st = M_RUN;
                     else if (bk) n_st = M_DBG;
            M_DEEP:  if (ext_reset || wev) n_st = M_WRST;
            M_WRST:  if (m_cnt == 7) n_st = M_RUN;
            default: if (ext_reset) n_st = M_WRST; else if (go) n_st = M_RUN;
        endcase
        n_cnt = (m_st == M_WRST && n_st == M_WRST) ? m_cnt + 1 : 0;
        wok = (m_st == M_RUN) || (m_st == M_DBG);
        n_cfg = m_cfg; n_flag = m_flag; n_hold = m_hold; n_latch = m_latch;
        if (m_st == M_WRST) n_cfg = 3'b0;
        else if (reg_wr && wok) n_cfg = reg_wdata[2:0];
        if (reg_wr && wok && reg_wdata[4]) begin n_flag = 0; n_hold = 0; end
        if (m_st == M_DEEP && n_st == M_WRST) n_flag = 1;
        if (m_st != M_DEEP && n_st == M_DEEP) begin
            if (!m_hold) n_latch = pin_ctrl_in;
            n_hold = 1;
        end
        m_stat = exp_status(m_st, m_cfg, dbg_valid, dbg_cmd);
        @(posedge clk); #2;
        m_st = n_st; m_cnt = n_cnt; m_cfg = n_cfg; m_flag = n_flag;
        m_hold = n_hold; m_latch = n_latch;
        compare_all();
    endtask

    task automatic quiet();
        stop_strobe = 0; ext_reset = 0; wake_pin_n = 1; timer_wake = 0;
        dbg_valid = 0; dbg_cmd = 0; reg_wr = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1; reg_wdata = d; tick(); reg_wr = 0;
    endtask

    task automatic cmd(input logic [1:0] c);
        dbg_valid = 1; dbg_cmd = c; tick(); dbg_valid = 0; dbg_cmd = 0;
    endtask

    task automatic stop_now();
        stop_strobe = 1; tick(); stop_strobe = 0;
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL R1 watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd48611));
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1 core_clk_en", core_clk_en, 1);
        chk("R1 dbg_clk_en", dbg_clk_en, 1);
        chk("R1 core_pwr_en", core_pwr_en, 1);
        chk("R1 reset_req", reset_req, 0);
        chk("R1 pin_hold", pin_hold, 0);
        chk("R1 reg_rdata", reg_rdata, 0);
        chk("R1 dbg_status", dbg_status, 0);
        por_n = 1;
        tick(); tick();

        // deep stop, pin latch, disabled timer, wake pin exit, reset length
        wr(8'h02);
        chk("R13 cfg written in run", reg_rdata, 8'h02);
        pin_ctrl_in = 8'hA5;
        stop_now();
        chk("R2 deep entered", core_pwr_en, 0);
        chk("R8 hold on deep entry", pin_hold, 1);
        pin_ctrl_in = 8'h3C;
        tick();
        chk("R8 held pins", pin_ctrl_out, 8'hA5);
        timer_wake = 1; tick(); timer_wake = 0;
        chk("R5 disabled timer ignored", core_pwr_en, 0);
        wake_pin_n = 0; tick(); wake_pin_n = 1;
        chk("R5 wake pin exits deep", reset_req, 1);
        for (int i = 0; i < 7; i++) begin
            tick();
            chk("R6 reset held", reset_req, 1);
        end
        tick();
        chk("R6 reset released", reset_req, 0);
        chk("R6 run after reset", core_clk_en, 1);
        chk("R7 flag set cfg cleared", reg_rdata, 8'h08);
        chk("R8 pins still held", pin_ctrl_out, 8'hA5);
        wr(8'h00);
        chk("R9 zero ack no effect", reg_rdata, 8'h08);
        chk("R9 hold after zero ack", pin_hold, 1);
        wr(8'h10);
        chk("R9 ack clears flag reads 0", reg_rdata, 8'h00);
        chk("R9 ack releases pins", pin_ctrl_out, 8'h3C);

        // R10: timer wake beats stop
        wr(8'h06);
        stop_strobe = 1; timer_wake = 1; tick(); quiet();
        chk("R10 stays in run", core_clk_en, 1);
        chk("R10 stays powered", core_pwr_en, 1);

        // R5: wake pin low at stop enters deep then exits
        wr(8'h02);
        wake_pin_n = 0; stop_strobe = 1; tick(); stop_strobe = 0;
        chk("R5 deep despite low pin", core_pwr_en, 0);
        tick(); wake_pin_n = 1;
        chk("R5 immediate exit", reset_req, 1);
        repeat (8) tick();
        chk("R6 back in run", core_clk_en, 1);
        wr(8'h10);

        // R3 R11 R12: debug-enabled stop
        wr(8'h03);
        stop_now();
        chk("R3 forced light", core_pwr_en, 1);
        chk("R3 dbg clock kept", dbg_clk_en, 1);
        chk("R3 regulator full", reg_full_en, 1);
        cmd(2'd1);
        chk("R11 mem in stop", dbg_status, 2);
        cmd(2'd2);
        chk("R12 background wakes", in_debug, 1);
        chk("R12 background ok", dbg_status, 1);
        cmd(2'd1);
        chk("R12 mem in debug", dbg_status, 1);
        cmd(2'd3);
        chk("R12 go to run", in_debug, 0);
        chk("R12 go core clock", core_clk_en, 1);

        // R11 R12 R13 R4: plain light stop
        wr(8'h00);
        stop_now();
        chk("R3 dbg clock off", dbg_clk_en, 0);
        cmd(2'd2);
        chk("R11 no response", dbg_status, 0);
        chk("R12 no background", in_debug, 0);
        wr(8'h07);
        chk("R13 write ignored in stop", reg_rdata, 8'h00);
        wake_pin_n = 0; tick(); wake_pin_n = 1;
        chk("R4 pin wakes light", core_clk_en, 1);
        cmd(2'd2);
        chk("R12 rejected without enable", dbg_status, 3);
        wr(8'h04);
        stop_now();
        timer_wake = 1; tick(); timer_wake = 0;
        chk("R4 timer wakes light", core_clk_en, 1);

        // R4 R7: external reset from light stop
        wr(8'h00);
        stop_now();
        ext_reset = 1; tick(); ext_reset = 0;
        chk("R4 ext reset", reset_req, 1);
        repeat (8) tick();
        chk("R7 flag not set", reg_rdata, 8'h00);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            stop_strobe = ($urandom % 100) < 10;
            ext_reset   = ($urandom % 100) < 1;
            wake_pin_n  = ($urandom % 100) >= 4;
            timer_wake  = ($urandom % 100) < 5;
            reg_wr      = ($urandom % 100) < 8;
            reg_wdata   = 8'($urandom);
            dbg_valid   = ($urandom % 100) < 10;
            dbg_cmd     = 2'($urandom);
            pin_ctrl_in = NP'($urandom);
            tick();
        end
        quiet();
        tick();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule